// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent down counters behind one 32-bit register port. Each channel has a load value, a live count, a control word and a background reload value. A shared interrupt group collects one underflow flag per channel, with a mask and a masked view, and drives a single interrupt line. Counting advances only on cycles where the tick-enable input is high. This input is the timer time base, already brought into the register clock domain. A per-channel prescaler then divides it by 1, 16 or 256.

Software programs a channel by writing its count, then its control word. A channel can run free, wrapping to all-ones. It can run periodically, reloading from the background value. It can also fire once and stop. The background value can be rewritten at any time. It is only used at the next underflow, so a new period takes effect without disturbing the count in progress. Elapsed time can be read as the bitwise inverse of the live count.

Top module: `mctimer_top`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Register map, byte addresses with bits 1:0 ignored. 0x00 is the interrupt mask, 0x04 raw status, 0x08 masked status, and 0x0C clear (write-one, reads zero). Channel n (0..3) uses base 0x10+0x10*n: +0x0 load, +0x4 live count (read-only, writes ignored), +0x8 control, +0xC background value. Other addresses read zero.
- R3: Control bits: 7 enable, 6 periodic, 3:2 prescale select, 1 selects 32-bit width, 0 one-shot. Bits 5:4 and 31:8 read zero.
- R4: A load write sets the live count from the next cycle and releases a stopped one-shot channel.
- R5: A counting step happens only when the channel is enabled, not stopped, and `tick_en` is high on the final prescaler tick. Select 00 steps on every tick, 01 on every 16th and 10 or 11 on every 256th. A step from a non-zero count subtracts one.
- R6: One-shot (bit 0 set, takes priority over bit 6): a step at zero leaves the count at zero, sets the raw flag, and stops the channel until a load or control write.
- R7: Free-running (bits 0 and 6 clear): a step at zero wraps to all-ones of the selected width and sets the raw flag.
- R8: Periodic (bit 6 set, bit 0 clear): a step at zero reloads the background value (cut to width) and sets the raw flag. A background write never changes the live count.
- R9: With bit 1 clear the live count reads only its low 16 bits, with the upper half zero, and wraps to 0xFFFF.
- R10: An underflow of channel n sets raw bit n. Writing one to bit n at 0x0C clears it, and an underflow in the same cycle wins. Masked status is raw AND mask, and `irq` is the OR of the masked bits.
- R11: While enable is clear the count is frozen and the prescaler is held at its start. After re-enabling, a full prescale interval passes before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time base enable, one cycle per timer tick |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of the masked underflow flags |

## Verification
The bench targets the zero-count step in each mode. A design that stepped before zero would raise the flag one tick early. One that wrapped the wrong way would show the wrong value afterwards. A one-shot channel that failed to stop would keep wrapping. The bench changes the background value mid-period, so a design that copied it straight into the count would be caught. It counts ticks exactly to the 16th and 256th step, so an off-by-one prescaler shows up. It also re-enables after a partial interval, which exposes a prescaler that keeps its old phase. A masked-off flag must leave `irq` low.

// File: rtl/mctimer_pkg.sv
package mctimer_pkg;

  localparam int unsigned DW = 32;

  // global register slots (reg_addr[3:2] inside group 0)
  localparam logic [1:0] G_MASK = 2'd0;
  localparam logic [1:0] G_RAW  = 2'd1;
  localparam logic [1:0] G_MIS  = 2'd2;
  localparam logic [1:0] G_CLR  = 2'd3;

  // per-channel register slots
  localparam logic [1:0] F_LOAD = 2'd0;
  localparam logic [1:0] F_CNT  = 2'd1;
  localparam logic [1:0] F_CTRL = 2'd2;
  localparam logic [1:0] F_BG   = 2'd3;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] psel;
    logic       w32;
    logic       oneshot;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [DW-1:0] w);
    ctrl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.psel     = w[3:2];
    c.w32      = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
    logic [DW-1:0] w;
    w      = '0;
    w[7]   = c.en;
    w[6]   = c.periodic;
    w[3:2] = c.psel;
    w[1]   = c.w32;
    w[0]   = c.oneshot;
    return w;
  endfunction

endpackage

// File: rtl/mctimer_rstsync.sv
module mctimer_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mctimer_presc.sv
module mctimer_presc #(
  parameter int unsigned PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick_en,
  input  logic [1:0] psel,
  output logic       step
);
  logic [PW-1:0] pcnt_q, pcnt_d, lim;

  always_comb begin
    case (psel)
      2'b00:   lim = '0;
      2'b01:   lim = PW'(15);
      default: lim = PW'(255);
    endcase
  end

  assign step = tick_en & ~clr & (pcnt_q == lim);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)          pcnt_d = '0;
    else if (tick_en) pcnt_d = step ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R11: a disabled prescaler sits at its start value
  assert_presc_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt_q == '0));
endmodule

// File: rtl/mctimer_chan.sv
module mctimer_chan
  import mctimer_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_bg,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] bg_o,
  output logic [DW-1:0] cnt_o,
  output logic          uf_o
);
  localparam logic [DW-1:0] M16 = DW'(32'h0000_FFFF);

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] load_q, load_d, bg_q, bg_d, cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [DW-1:0] wmask, cur;
  logic          step, adv, at_zero;

  mctimer_presc #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~ctrl_q.en),
    .tick_en (tick_en),
    .psel    (ctrl_q.psel),
    .step    (step)
  );

  assign wmask   = ctrl_q.w32 ? '1 : M16;
  assign cur     = cnt_q & wmask;
  assign at_zero = (cur == '0);
  assign adv     = step & ~done_q;
  assign uf_o    = adv & at_zero & ~wr_load;

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    bg_d   = bg_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (adv) begin
      if (!at_zero)              cnt_d = cur - 1'b1;
      else if (ctrl_q.oneshot) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end
      else if (ctrl_q.periodic)  cnt_d = bg_q & wmask;
      else                       cnt_d = wmask;
    end
    if (wr_load) begin
      load_d = wdata;
      cnt_d  = wdata;
      done_d = 1'b0;
    end
    if (wr_ctrl) begin
      ctrl_d = word_to_ctrl(wdata);
      done_d = 1'b0;
    end
    if (wr_bg) bg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      bg_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      bg_q   <= bg_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign bg_o   = bg_q;
  assign cnt_o  = cur;

  assert_no_step_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_load && !adv) |=> $stable(cnt_q));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_zero && !wr_load) |=> (cnt_q == $past(cur) - 1'b1));

  assert_oneshot_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_load && !wr_ctrl) |=> (done_q && $stable(cnt_q)));

  assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_zero && !wr_load && !ctrl_q.oneshot && !ctrl_q.periodic)
      |=> (cnt_q == $past(wmask)));

  assert_bg_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_zero && !wr_load && !ctrl_q.oneshot && ctrl_q.periodic)
      |=> (cnt_q == ($past(bg_q) & $past(wmask))));

  assert_frozen_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_load) |=> $stable(cnt_q));
endmodule

// File: rtl/mctimer_irq.sv
module mctimer_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] uf,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mis_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, mask_d, raw_q, raw_d, clr_bits;

  assign clr_bits = wr_clr ? wbits : '0;

  always_comb begin
    mask_d = wr_mask ? wbits : mask_q;
    raw_d  = (raw_q & ~clr_bits) | uf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      mask_q <= mask_d;
      raw_q  <= raw_d;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign mis_o  = raw_q & mask_q;
  assign irq_o  = |mis_o;

  assert_raw_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf) |=> ((raw_q & $past(uf)) == $past(uf)));

  assert_raw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((raw_q & $past(wbits & ~uf)) == '0));

  assert_raw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: rtl/mctimer_top.sv
module mctimer_top
  import mctimer_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned AW   = 8,
  parameter int unsigned PW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int unsigned GW = AW - 4;

  logic            rst_n_i;
  logic [GW-1:0]   grp;
  logic [1:0]      slot;
  logic            glb_hit;
  logic [N_CH-1:0] ch_hit, uf_v, mask_v, raw_v, mis_v;
  logic            unused_addr_lsb;

  ctrl_t         ctrl_a [N_CH];
  logic [DW-1:0] load_a [N_CH];
  logic [DW-1:0] bg_a   [N_CH];
  logic [DW-1:0] cnt_a  [N_CH];

  mctimer_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign grp             = reg_addr[AW-1:4];
  assign slot            = reg_addr[3:2];
  assign glb_hit         = (grp == '0);
  assign unused_addr_lsb = ^reg_addr[1:0];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_hit[i] = (grp == GW'(i + 1));

    mctimer_chan #(.PW(PW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .tick_en (tick_en),
      .wr_load (reg_wr & ch_hit[i] & (slot == F_LOAD)),
      .wr_ctrl (reg_wr & ch_hit[i] & (slot == F_CTRL)),
      .wr_bg   (reg_wr & ch_hit[i] & (slot == F_BG)),
      .wdata   (reg_wdata),
      .ctrl_o  (ctrl_a[i]),
      .load_o  (load_a[i]),
      .bg_o    (bg_a[i]),
      .cnt_o   (cnt_a[i]),
      .uf_o    (uf_v[i])
    );
  end

  mctimer_irq #(.N(N_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_mask (reg_wr & glb_hit & (slot == G_MASK)),
    .wr_clr  (reg_wr & glb_hit & (slot == G_CLR)),
    .wbits   (reg_wdata[N_CH-1:0]),
    .uf      (uf_v),
    .mask_o  (mask_v),
    .raw_o   (raw_v),
    .mis_o   (mis_v),
    .irq_o   (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (glb_hit) begin
      case (slot)
        G_MASK:  reg_rdata = 32'(mask_v);
        G_RAW:   reg_rdata = 32'(raw_v);
        G_MIS:   reg_rdata = 32'(mis_v);
        default: reg_rdata = '0;
      endcase
    end
    for (int i = 0; i < N_CH; i++) begin
      if (ch_hit[i]) begin
        case (slot)
          F_LOAD:  reg_rdata = load_a[i];
          F_CNT:   reg_rdata = cnt_a[i];
          F_CTRL:  reg_rdata = ctrl_to_word(ctrl_a[i]);
          default: reg_rdata = bg_a[i];
        endcase
      end
    end
  end

  // R1: straight after reset release nothing is pending
  assert_irq_quiet_after_reset_R1: assert property (@(posedge clk)
    (!rst_n_i) |=> !irq);
endmodule

// File: tb/tb_mctimer_top.sv
module tb_mctimer_top;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  mctimer_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 32'h0000_1234, 32'h0,          8'd4},  // R4 load ch0
    '{1'b0, 8'h10, 32'h0,         32'h0000_1234, 8'd2},  // R2 load readback
    '{1'b0, 8'h14, 32'h0,         32'h0000_1234, 8'd4},  // R4 live count follows load
    '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,          8'd3},  // R3 all ones to control
    '{1'b0, 8'h18, 32'h0,         32'h0000_00CF, 8'd3},  // R3 only defined bits kept
    '{1'b1, 8'h18, 32'h0,         32'h0,          8'd3},
    '{1'b1, 8'h4C, 32'hA5A5_A5A5, 32'h0,          8'd8},  // R8 background ch3
    '{1'b0, 8'h4C, 32'h0,         32'hA5A5_A5A5, 8'd2},  // R2 background readback
    '{1'b0, 8'h44, 32'h0,         32'h0,          8'd8},  // R8 count untouched
    '{1'b1, 8'h14, 32'h0000_0055, 32'h0,          8'd2},  // R2 write to live count
    '{1'b0, 8'h14, 32'h0,         32'h0000_1234, 8'd2},  // R2 ignored
    '{1'b0, 8'h50, 32'h0,         32'h0,          8'd2},  // R2 unmapped
    '{1'b1, 8'h00, 32'h0000_00FF, 32'h0,          8'd10}, // R10 mask
    '{1'b0, 8'h00, 32'h0,         32'h0000_000F, 8'd10}, // R10 mask width
    '{1'b1, 8'h00, 32'h0,         32'h0,          8'd10}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick_en   = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    rst_n     = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(8'h00, v); check("R1 mask", v, 32'h0);
    rd(8'h04, v); check("R1 raw", v, 32'h0);
    rd(8'h18, v); check("R1 control", v, 32'h0);
    rd(8'h34, v); check("R1 count", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R7 R9 R10: ch1 free-running, 16-bit
    wr(8'h00, 32'h2);
    wr(8'h20, 32'h2);
    wr(8'h28, 32'h80);
    ticks(1); rd(8'h24, v); check("R5 step", v, 32'h1);
    ticks(1); rd(8'h24, v); check("R5 reach zero", v, 32'h0);
    rd(8'h04, v); check("R10 no flag before zero step", v & 32'h2, 32'h0);
    ticks(1); rd(8'h24, v); check("R9 wrap to 0xFFFF", v, 32'h0000_FFFF);
    rd(8'h04, v); check("R7 raw flag", v & 32'h2, 32'h2);
    rd(8'h08, v); check("R10 masked", v, 32'h2);
    check("R10 irq high", 32'(irq), 32'h1);
    wr(8'h0C, 32'h2);
    rd(8'h04, v); check("R10 cleared", v & 32'h2, 32'h0);
    check("R10 irq low", 32'(irq), 32'h0);
    wr(8'h28, 32'h0);

    // R8 periodic ch2
    wr(8'h3C, 32'h5);
    wr(8'h30, 32'h1);
    wr(8'h38, 32'hC2);
    ticks(2); rd(8'h34, v); check("R8 reload", v, 32'h5);
    rd(8'h04, v); check("R8 raw flag", v & 32'h4, 32'h4);
    wr(8'h3C, 32'h9);
    rd(8'h34, v); check("R8 bg write leaves count", v, 32'h5);
    ticks(6); rd(8'h34, v); check("R8 new period", v, 32'h9);
    wr(8'h38, 32'h0);

    // R6 one-shot ch3
    wr(8'h40, 32'h1);
    wr(8'h48, 32'h83);
    ticks(2); rd(8'h44, v); check("R6 stop at zero", v, 32'h0);
    rd(8'h04, v); check("R6 raw flag", v & 32'h8, 32'h8);
    rd(8'h08, v); check("R10 masked off", v & 32'h8, 32'h0);
    check("R10 irq stays low", 32'(irq), 32'h0);
    wr(8'h0C, 32'h8);
    ticks(5); rd(8'h44, v); check("R6 stays stopped", v, 32'h0);
    rd(8'h04, v); check("R6 no repeat flag", v & 32'h8, 32'h0);
    wr(8'h40, 32'h3);
    rd(8'h44, v); check("R4 load releases", v, 32'h3);
    ticks(1); rd(8'h44, v); check("R4 resumes", v, 32'h2);

    // R5 prescaler on ch0
    wr(8'h10, 32'd100);
    wr(8'h18, 32'h86);
    ticks(15); rd(8'h14, v); check("R5 div16 not yet", v, 32'd100);
    ticks(1);  rd(8'h14, v); check("R5 div16 step", v, 32'd99);
    wr(8'h18, 32'h8A);
    ticks(255); rd(8'h14, v); check("R5 div256 not yet", v, 32'd99);
    ticks(1);   rd(8'h14, v); check("R5 div256 step", v, 32'd98);

    // R11 freeze and prescaler restart
    wr(8'h18, 32'h86);
    ticks(10);
    wr(8'h18, 32'h06);
    ticks(20); rd(8'h14, v); check("R11 frozen", v, 32'd98);
    wr(8'h18, 32'h86);
    ticks(15); rd(8'h14, v); check("R11 full interval", v, 32'd98);
    ticks(1);  rd(8'h14, v); check("R11 step after restart", v, 32'd97);

    // R1 reset mid-run
    do_reset();
    rd(8'h10, v); check("R1 load after reset", v, 32'h0);
    rd(8'h38, v); check("R1 control after reset", v, 32'h0);
    rd(8'h4C, v); check("R1 background after reset", v, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule